// File: doc/BRIEF.md
# Indexed Codec Control Register Port

This block is the host-facing control interface of an audio codec. The host sees four byte-wide ports selected by a 2-bit address: an index port, a data port that reaches an internal bank of indirect 8-bit registers, a status port, and a polled-I/O data port. The index port selects which indirect register the data port reaches. It also carries two mode controls and reports a busy flag.

After reset, the codec reports busy for a fixed number of clock cycles. During that time the data port reads a fixed busy pattern and drops writes. A software power-down input has the same effect while it is held. The data-format and interface-configuration registers are protected by a mode-change-enable bit: they can only be rewritten while that bit is set. The playback-enable and capture-enable bits are the exception and can be changed at any time. The DAC mute output follows the mode-change-enable bit.

The status port combines live flags from the sample engine with two sticky flags. The interrupt flag is cleared by any write to the status port. The sample-error flag is cleared by reading the status port. When the transfer-request-disable control is set, DMA requests are held off while the interrupt flag is up.

Top module: `codec_regport`

## Requirements
- R1: After reset the busy output is high for exactly BUSY_CYCLES clock cycles and then low. Every indirect register resets to 0x00, the index resets to 0, transfer-request-disable resets to 0 and mode-change-enable resets to 1.
- R2: A write to port 0 (index) stores the register index from bits [4:0], transfer-request-disable from bit 5 and mode-change-enable from bit 6. A read of port 0 returns {busy, mode-change-enable, transfer-request-disable, index[4:0]}, with busy in bit 7. Bit 7 of a write has no effect.
- R3: While busy is high, whether during the post-reset count or while `powerdown` is held, a read of port 1 (data) returns 0x80 and a write to port 1 leaves every register unchanged. Releasing `powerdown` restarts the BUSY_CYCLES count.
- R4: Register index 8 (data format) changes only when mode-change-enable is 1. For register index 9 (interface configuration), bits [7:2] change only when mode-change-enable is 1, while bit 0 (playback enable) and bit 1 (capture enable) take the written value on any data write. `data_format`, `iface_cfg`, `play_en` and `capt_en` show these registers.
- R5: `dac_mute` equals the mode-change-enable bit at all times.
- R6: `dma_req_play` is `drq_play_in` AND playback enable, and `dma_req_capt` is `drq_capt_in` AND capture enable. Both are forced low while transfer-request-disable and the interrupt flag are both 1.
- R7: A read of port 2 (status) returns, from bit 7 down to bit 0: `cap_flags[2:0]` (upper, left, ready), sample error, `play_flags[2:0]` (upper, left, ready), interrupt active.
- R8: An `int_pulse` sets the interrupt flag (`irq`). Any write to port 2 clears it, whatever the data, except that a pulse in the same cycle keeps it set.
- R9: An `err_pulse` sets the sample-error flag. A read of port 2 returns the flag and then clears it, except that a pulse in the same cycle keeps it set.
- R10: With REG_COUNT = 16, indices 16 to 31 read 0x00 over port 1 and writes to them are discarded, with no aliasing onto indices 0 to 15.
- R11: `mute_left` is bit 7 of register index 6 and `mute_right` is bit 7 of register index 7.
- R12: `host_rdata` is registered. It takes the addressed port's value at the clock edge where `host_rd` is high, reflecting state before that edge, and holds otherwise. It resets to 0x00.
- R13: A write to port 3 (polled I/O) loads `pio_out`, and a read of port 3 returns `pio_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 2 | Port select: 0 index, 1 data, 2 status, 3 polled I/O |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| powerdown | input | 1 | Software power-down; forces busy |
| int_pulse | input | 1 | Sets the interrupt flag |
| err_pulse | input | 1 | Sets the sample-error flag |
| cap_flags | input | 3 | Live capture flags {upper, left, ready} |
| play_flags | input | 3 | Live playback flags {upper, left, ready} |
| drq_play_in | input | 1 | Playback DMA request from the engine |
| drq_capt_in | input | 1 | Capture DMA request from the engine |
| pio_in | input | 8 | Polled-I/O read value |
| pio_out | output | 8 | Polled-I/O write value |
| busy | output | 1 | Initialization / power-down busy |
| dac_mute | output | 1 | DAC mute, follows mode-change-enable |
| irq | output | 1 | Interrupt flag |
| play_en | output | 1 | Playback enable |
| capt_en | output | 1 | Capture enable |
| dma_req_play | output | 1 | Gated playback DMA request |
| dma_req_capt | output | 1 | Gated capture DMA request |
| data_format | output | 8 | Data-format register contents |
| iface_cfg | output | 8 | Interface-configuration register contents |
| mute_left | output | 1 | Left volume mute bit |
| mute_right | output | 1 | Right volume mute bit |

## Verification
The bench goes after the gate on register 9. There it writes all ones with mode-change-enable clear and expects only the two enable bits to move. A design that gated the whole register would lose the on-the-fly enable, and one that gated nothing would corrupt the format bits. It also places writes and reads inside the busy window and during power-down, where a design that leaked data writes would show stale values after busy drops. It collides a status write with an interrupt pulse, and a status read with an error pulse, so that a wrong priority shows as a flag that clears early. It writes to indices above 15 to catch a bank that aliases them onto low registers.

// File: rtl/codec_regport_pkg.sv
package codec_regport_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 5;

  typedef enum logic [1:0] {
    PORT_INDEX  = 2'd0,
    PORT_DATA   = 2'd1,
    PORT_STATUS = 2'd2,
    PORT_PIO    = 2'd3
  } port_sel_e;

  localparam logic [IDX_W-1:0] IDX_VOL_L  = 5'd6;
  localparam logic [IDX_W-1:0] IDX_VOL_R  = 5'd7;
  localparam logic [IDX_W-1:0] IDX_FORMAT = 5'd8;
  localparam logic [IDX_W-1:0] IDX_IFACE  = 5'd9;

  localparam int IX_TRD   = 5;
  localparam int IX_MCE   = 6;
  localparam int CFG_PLAY = 0;
  localparam int CFG_CAPT = 1;
  localparam int VOL_MUTE = 7;

  localparam logic [DATA_W-1:0] BUSY_PATTERN = 8'h80;
endpackage

// File: rtl/codec_busy_timer.sv
module codec_busy_timer #(
  parameter int BUSY_CYCLES = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic powerdown,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || powerdown) cnt_q <= CW'(BUSY_CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
  end

  assign busy = powerdown || (cnt_q != '0);

  // R1: the cycle after a reset edge always reports busy
  assert_busy_after_reset_R1: assert property (@(posedge clk) rst |=> busy);
endmodule

// File: rtl/codec_index_reg.sv
module codec_index_reg
  import codec_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [IDX_W-1:0]  idx,
  output logic              trd,
  output logic              mce
);
  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
      trd <= 1'b0;
      mce <= 1'b1;
    end else if (wr_en) begin
      idx <= wdata[IDX_W-1:0];
      trd <= wdata[IX_TRD];
      mce <= wdata[IX_MCE];
    end
  end

  // R2: an index write lands the selected index on the next cycle
  assert_index_load_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (idx == $past(wdata[IDX_W-1:0])));
endmodule

// File: rtl/codec_reg_bank.sv
module codec_reg_bank
  import codec_regport_pkg::*;
#(
  parameter int REG_COUNT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mce,
  output logic [DATA_W-1:0] rd_value,
  output logic [DATA_W-1:0] fmt,
  output logic [DATA_W-1:0] iface,
  output logic [DATA_W-1:0] vol_l,
  output logic [DATA_W-1:0] vol_r
);
  localparam int SEL_W = $clog2(REG_COUNT);

  logic [DATA_W-1:0] regs [REG_COUNT];
  logic [SEL_W-1:0]  sel;
  logic              in_range;
  logic [DATA_W-1:0] cur, nxt;

  assign sel = idx[SEL_W-1:0];

  generate
    if (REG_COUNT == 32) begin : g_full
      assign in_range = 1'b1;
    end else begin : g_partial
      assign in_range = (idx < IDX_W'(REG_COUNT));
    end
  endgenerate

  always_comb begin
    cur = regs[sel];
    nxt = wdata;
    if (idx == IDX_FORMAT && !mce)
      nxt = cur;
    else if (idx == IDX_IFACE && !mce)
      nxt = {cur[DATA_W-1:2], wdata[CFG_CAPT], wdata[CFG_PLAY]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_COUNT; i++) regs[i] <= '0;
    end else if (wr_en && in_range) begin
      regs[sel] <= nxt;
    end
  end

  assign rd_value = in_range ? regs[sel] : '0;
  assign fmt      = regs[IDX_FORMAT[SEL_W-1:0]];
  assign iface    = regs[IDX_IFACE[SEL_W-1:0]];
  assign vol_l    = regs[IDX_VOL_L[SEL_W-1:0]];
  assign vol_r    = regs[IDX_VOL_R[SEL_W-1:0]];

  // R4: format register frozen while mode change is disabled
  assert_format_locked_R4: assert property (@(posedge clk) disable iff (rst)
    !mce |=> $stable(fmt));
  // R4: upper interface-configuration bits frozen while mode change is disabled
  assert_iface_locked_R4: assert property (@(posedge clk) disable iff (rst)
    !mce |=> $stable(iface[DATA_W-1:2]));
endmodule

// File: rtl/codec_status.sv
module codec_status
  import codec_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              int_set,
  input  logic              err_set,
  input  logic              wr_clr,
  input  logic              rd_clr,
  input  logic [2:0]        cap_flags,
  input  logic [2:0]        play_flags,
  output logic              int_flag,
  output logic [DATA_W-1:0] status_byte
);
  logic err_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      int_flag <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      if (int_set)     int_flag <= 1'b1;
      else if (wr_clr) int_flag <= 1'b0;
      if (err_set)     err_flag <= 1'b1;
      else if (rd_clr) err_flag <= 1'b0;
    end
  end

  assign status_byte = {cap_flags, err_flag, play_flags, int_flag};

  // R8: a status write without a concurrent pulse clears the interrupt
  assert_int_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_clr && !int_set) |=> !int_flag);
  // R9: a status read without a concurrent pulse clears the sample error
  assert_err_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !err_set) |=> !status_byte[4]);
endmodule

// File: rtl/codec_regport.sv
module codec_regport
  import codec_regport_pkg::*;
#(
  parameter int REG_COUNT   = 16,
  parameter int BUSY_CYCLES = 24
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  host_addr,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  input  logic        powerdown,
  input  logic        int_pulse,
  input  logic        err_pulse,
  input  logic [2:0]  cap_flags,
  input  logic [2:0]  play_flags,
  input  logic        drq_play_in,
  input  logic        drq_capt_in,
  input  logic [7:0]  pio_in,
  output logic [7:0]  pio_out,
  output logic        busy,
  output logic        dac_mute,
  output logic        irq,
  output logic        play_en,
  output logic        capt_en,
  output logic        dma_req_play,
  output logic        dma_req_capt,
  output logic [7:0]  data_format,
  output logic [7:0]  iface_cfg,
  output logic        mute_left,
  output logic        mute_right
);
  logic [IDX_W-1:0]  idx;
  logic              trd, mce;
  logic [DATA_W-1:0] bank_rd, status_byte, vol_l, vol_r, rd_mux;
  logic              wr_index, wr_data, wr_status, wr_pio, rd_status, hold_dma;

  assign wr_index  = host_wr && (host_addr == PORT_INDEX);
  assign wr_data   = host_wr && (host_addr == PORT_DATA) && !busy;
  assign wr_status = host_wr && (host_addr == PORT_STATUS);
  assign wr_pio    = host_wr && (host_addr == PORT_PIO);
  assign rd_status = host_rd && (host_addr == PORT_STATUS);

  codec_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst(rst), .powerdown(powerdown), .busy(busy)
  );

  codec_index_reg u_index (
    .clk(clk), .rst(rst), .wr_en(wr_index), .wdata(host_wdata),
    .idx(idx), .trd(trd), .mce(mce)
  );

  codec_reg_bank #(.REG_COUNT(REG_COUNT)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_data), .idx(idx), .wdata(host_wdata),
    .mce(mce), .rd_value(bank_rd), .fmt(data_format), .iface(iface_cfg),
    .vol_l(vol_l), .vol_r(vol_r)
  );

  codec_status u_status (
    .clk(clk), .rst(rst), .int_set(int_pulse), .err_set(err_pulse),
    .wr_clr(wr_status), .rd_clr(rd_status), .cap_flags(cap_flags),
    .play_flags(play_flags), .int_flag(irq), .status_byte(status_byte)
  );

  always_comb begin
    case (host_addr)
      PORT_INDEX:  rd_mux = {busy, mce, trd, idx};
      PORT_DATA:   rd_mux = busy ? BUSY_PATTERN : bank_rd;
      PORT_STATUS: rd_mux = status_byte;
      default:     rd_mux = pio_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
      pio_out    <= '0;
    end else begin
      if (host_rd) host_rdata <= rd_mux;
      if (wr_pio)  pio_out    <= host_wdata;
    end
  end

  assign dac_mute     = mce;
  assign play_en      = iface_cfg[CFG_PLAY];
  assign capt_en      = iface_cfg[CFG_CAPT];
  assign hold_dma     = trd && irq;
  assign dma_req_play = drq_play_in && play_en && !hold_dma;
  assign dma_req_capt = drq_capt_in && capt_en && !hold_dma;
  assign mute_left    = vol_l[VOL_MUTE];
  assign mute_right   = vol_r[VOL_MUTE];

  // R5: setting mode-change-enable through the index port mutes the DAC
  assert_mce_mutes_R5: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == PORT_INDEX && host_wdata[IX_MCE]) |=> dac_mute);
  // R6: no DMA request leaves while the interrupt holds transfers off
  assert_dma_held_R6: assert property (@(posedge clk) disable iff (rst)
    (trd && irq) |-> !(dma_req_play || dma_req_capt));
  // R3: data-port read while busy yields the busy pattern
  assert_busy_read_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && host_rd && host_addr == PORT_DATA) |=> (host_rdata == 8'h80));
  // R13: polled-I/O write reaches pio_out on the next cycle
  assert_pio_write_R13: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == PORT_PIO) |=> (pio_out == $past(host_wdata)));
endmodule

// File: tb/sim_codec_regport.sv
module sim_codec_regport;
  localparam int CLK_PERIOD = 10;
  localparam int REGS = 16;
  localparam int BUSY = 24;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] host_addr = '0;
  logic host_wr = 0, host_rd = 0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic powerdown = 0, int_pulse = 0, err_pulse = 0;
  logic [2:0] cap_flags = '0, play_flags = '0;
  logic drq_play_in = 0, drq_capt_in = 0;
  logic [7:0] pio_in = '0, pio_out;
  logic busy, dac_mute, irq, play_en, capt_en, dma_req_play, dma_req_capt;
  logic [7:0] data_format, iface_cfg;
  logic mute_left, mute_right;

  int checks = 0, failures = 0, cyc = 0;

  codec_regport #(.REG_COUNT(REGS), .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .powerdown(powerdown), .int_pulse(int_pulse), .err_pulse(err_pulse),
    .cap_flags(cap_flags), .play_flags(play_flags), .drq_play_in(drq_play_in),
    .drq_capt_in(drq_capt_in), .pio_in(pio_in), .pio_out(pio_out),
    .busy(busy), .dac_mute(dac_mute), .irq(irq), .play_en(play_en),
    .capt_en(capt_en), .dma_req_play(dma_req_play), .dma_req_capt(dma_req_capt),
    .data_format(data_format), .iface_cfg(iface_cfg),
    .mute_left(mute_left), .mute_right(mute_right)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [7:0] m_regs [32];
  int m_cnt = BUSY;
  logic [4:0] m_idx = '0;
  logic m_trd = 0, m_mce = 1, m_int = 0, m_ser = 0, pre_busy;
  logic [7:0] m_rdata = '0, m_pio = '0;

  function automatic logic [7:0] m_status();
    return {cap_flags, m_ser, play_flags, m_int};
  endfunction

  function automatic logic [7:0] m_read(logic [1:0] a, logic b);
    case (a)
      2'd0: return {b, m_mce, m_trd, m_idx};
      2'd1: return b ? 8'h80 : ((int'(m_idx) < REGS) ? m_regs[m_idx] : 8'h00);
      2'd2: return m_status();
      default: return pio_in;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) m_regs[i] = 8'h00;
      m_cnt = BUSY; m_idx = '0; m_trd = 0; m_mce = 1;
      m_int = 0; m_ser = 0; m_rdata = '0; m_pio = '0;
    end else begin
      pre_busy = powerdown || (m_cnt != 0);
      if (host_rd) m_rdata = m_read(host_addr, pre_busy);
      if (host_wr) begin
        case (host_addr)
          2'd0: begin m_idx = host_wdata[4:0]; m_trd = host_wdata[5]; m_mce = host_wdata[6]; end
          2'd1: if (!pre_busy && int'(m_idx) < REGS) begin
                  if (m_idx == 5'd8) begin
                    if (m_mce) m_regs[8] = host_wdata;
                  end else if (m_idx == 5'd9) begin
                    if (m_mce) m_regs[9] = host_wdata;
                    else m_regs[9][1:0] = host_wdata[1:0];
                  end else m_regs[m_idx] = host_wdata;
                end
          2'd2: m_int = 0;
          default: m_pio = host_wdata;
        endcase
      end
      if (host_rd && host_addr == 2'd2) m_ser = 0;
      if (int_pulse) m_int = 1;
      if (err_pulse) m_ser = 1;
      if (powerdown) m_cnt = BUSY;
      else if (m_cnt > 0) m_cnt--;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R12", "host_rdata", host_rdata, m_rdata);
    chk("R1", "busy", busy, powerdown || (m_cnt != 0));
    chk("R5", "dac_mute", dac_mute, m_mce);
    chk("R4", "data_format", data_format, m_regs[8]);
    chk("R4", "iface_cfg", iface_cfg, m_regs[9]);
    chk("R4", "play_en", play_en, m_regs[9][0]);
    chk("R4", "capt_en", capt_en, m_regs[9][1]);
    chk("R6", "dma_req_play", dma_req_play, drq_play_in & m_regs[9][0] & ~(m_trd & m_int));
    chk("R6", "dma_req_capt", dma_req_capt, drq_capt_in & m_regs[9][1] & ~(m_trd & m_int));
    chk("R8", "irq", irq, m_int);
    chk("R11", "mute_left", mute_left, m_regs[6][7]);
    chk("R11", "mute_right", mute_right, m_regs[7][7]);
    chk("R13", "pio_out", pio_out, m_pio);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1;
    step();
    host_wr = 0;
  endtask

  task automatic rd_expect(logic [1:0] a, logic [7:0] exp, string req);
    host_addr = a; host_rd = 1;
    step();
    host_rd = 0;
    chk(req, "read", host_rdata, exp);
  endtask

  task automatic pulse_int();
    int_pulse = 1; step(); int_pulse = 0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 100 && busy; i++) step();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst = 0;
    // R1 R2: reset state seen through the index port
    rd_expect(2'd0, 8'hC0, "R2");
    rd_expect(2'd1, 8'h80, "R3");
    wr(2'd0, 8'h42);
    wr(2'd1, 8'h55);
    wait_ready();
    chk("R1", "busy released", busy, 1'b0);
    rd_expect(2'd1, 8'h00, "R3");
    // R4 format gate
    wr(2'd0, 8'h48); wr(2'd1, 8'hA5);
    rd_expect(2'd1, 8'hA5, "R4");
    wr(2'd0, 8'h08);
    chk("R5", "mute low", dac_mute, 1'b0);
    wr(2'd1, 8'h3C);
    rd_expect(2'd1, 8'hA5, "R4");
    wr(2'd0, 8'h09); wr(2'd1, 8'hFF);
    rd_expect(2'd1, 8'h03, "R4");
    chk("R4", "play_en on the fly", play_en, 1'b1);
    wr(2'd0, 8'h49);
    chk("R5", "mute high", dac_mute, 1'b1);
    wr(2'd1, 8'hF0);
    rd_expect(2'd1, 8'hF0, "R4");
    // R10 out of range
    wr(2'd0, 8'h52); wr(2'd1, 8'h77);
    rd_expect(2'd1, 8'h00, "R10");
    wr(2'd0, 8'h42);
    rd_expect(2'd1, 8'h00, "R10");
    // R11 volume mutes
    wr(2'd0, 8'h46); wr(2'd1, 8'h80);
    chk("R11", "left mute", mute_left, 1'b1);
    wr(2'd0, 8'h47); wr(2'd1, 8'h1F);
    chk("R11", "right mute", mute_right, 1'b0);
    // R7 R8 status and interrupt
    cap_flags = 3'b101; play_flags = 3'b010;
    pulse_int();
    rd_expect(2'd2, 8'hA5, "R7");
    chk("R8", "irq set", irq, 1'b1);
    wr(2'd2, 8'hFF);
    chk("R8", "irq cleared", irq, 1'b0);
    host_addr = 2'd2; host_wdata = 8'h00; host_wr = 1; int_pulse = 1;
    step();
    host_wr = 0; int_pulse = 0;
    chk("R8", "pulse beats clear", irq, 1'b1);
    wr(2'd2, 8'h00);
    // R9 sample error
    err_pulse = 1; step(); err_pulse = 0;
    rd_expect(2'd2, 8'hB4, "R9");
    rd_expect(2'd2, 8'hA4, "R9");
    // R6 DMA gating
    wr(2'd0, 8'h49); wr(2'd1, 8'h03);
    wr(2'd0, 8'h29);
    drq_play_in = 1; drq_capt_in = 1;
    pulse_int();
    chk("R6", "play held", dma_req_play, 1'b0);
    chk("R6", "capt held", dma_req_capt, 1'b0);
    wr(2'd2, 8'h00);
    chk("R6", "play released", dma_req_play, 1'b1);
    wr(2'd0, 8'h09);
    pulse_int();
    chk("R6", "auto mode", dma_req_capt, 1'b1);
    wr(2'd2, 8'h00);
    // R13 polled I/O
    wr(2'd3, 8'h5A);
    chk("R13", "pio_out", pio_out, 8'h5A);
    pio_in = 8'h3C;
    rd_expect(2'd3, 8'h3C, "R13");
    step();
    chk("R12", "rdata holds", host_rdata, 8'h3C);
    // R3 software powerdown
    powerdown = 1; step();
    chk("R3", "busy in powerdown", busy, 1'b1);
    wr(2'd0, 8'h42); wr(2'd1, 8'h99);
    rd_expect(2'd1, 8'h80, "R3");
    powerdown = 0;
    wait_ready();
    rd_expect(2'd1, 8'h00, "R3");
    // random traffic against the model
    for (int n = 0; n < 600; n++) begin
      host_addr   = 2'($urandom_range(0, 3));
      host_wdata  = 8'($urandom);
      host_wr     = ($urandom_range(0, 9) < 3);
      host_rd     = ($urandom_range(0, 9) < 3);
      int_pulse   = ($urandom_range(0, 9) == 0);
      err_pulse   = ($urandom_range(0, 9) == 0);
      powerdown   = ($urandom_range(0, 63) == 0);
      cap_flags   = 3'($urandom);
      play_flags  = 3'($urandom);
      drq_play_in = 1'($urandom);
      drq_capt_in = 1'($urandom);
      pio_in      = 8'($urandom);
      step();
    end
    summary();
    $finish;
  end
endmodule